// File: doc/BRIEF.md
# Flow-Through Burst SRAM Cycle Controller

This block is the control front end of a flow-through synchronous burst SRAM with a 32-bit word split into four byte lanes. On every rising clock edge it samples three chip enables, a sleep input, two address strobes, a burst-advance input and a write-control group. From these it classifies the cycle as idle, deselect, sleep, begin-burst, continue-burst or suspend-burst. It then either updates the internal array with a byte-masked write or sets up a read.

The two address strobes have different priorities. The processor strobe always opens a read, whatever the write controls say, so a write can only follow it on a later clock. The controller strobe opens either a read or a write. Inside a burst, the advance input either steps the two low address bits with wraparound or holds the current address.

Read data flows through without an output register. It is valid in the clock period right after the edge that sampled the read. The output enable is asynchronous. The data bus is split into separate input, output and output-enable ports, so the tri-state condition can be observed directly.

Top module: `sbc_top`

## Requirements
- R1: While reset is high at a clock edge, the data output enable `dq_oe` is low in the following period, and no burst is open afterwards: with both strobes high, a cycle reads nothing.
- R2: A cycle is a write only when `gw_n`=0, or when `bwe_n`=0 and at least one bit of `bw_n` is 0. With `gw_n`=1 and either `bwe_n`=1 or `bw_n`=4'b1111, the cycle is a read.
- R3: In a write, lane i (bits 8i+7:8i) is updated only if `bw_n[i]`=0. When `gw_n`=0, all four lanes are written.
- R4: If `pstrb_n`=0 while the device is selected and not asleep, the cycle begins a read at `addr`. The write controls have no effect on the array in that cycle.
- R5: If `cstrb_n`=0 while `pstrb_n`=1, the device is selected and not asleep, the cycle begins a burst at `addr`. It writes if R2 says write, and reads otherwise.
- R6: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe sampled while it is not selected is a deselect cycle: `dq_oe` goes low, nothing is written, and the burst is closed.
- R7: With `sleep`=1, all other controls are ignored. Nothing is written, `dq_oe` is low in the following period, and the burst is closed.
- R8: With both strobes high, an open burst and `adv_n`=0, the address becomes the previous one with its two low bits incremented modulo 4. The upper bits are unchanged.
- R9: With both strobes high, an open burst and `adv_n`=1, the address is reused unchanged.
- R10: `dq_oe` equals (the last sampled cycle was a read) AND NOT `oe_n`. It follows `oe_n` without waiting for a clock.
- R11: In the period after a write edge, `dq_oe` is low even if `oe_n`=0.
- R12: For a read sampled at an edge, `dq_out` carries the addressed word before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| sleep | input | 1 | Power-down request |
| pstrb_n | input | 1 | Processor address strobe, forces a read |
| cstrb_n | input | 1 | Controller address strobe |
| adv_n | input | 1 | Burst advance, low steps the address |
| gw_n | input | 1 | Global write, all lanes |
| bwe_n | input | 1 | Byte-write enable |
| bw_n | input | 4 | Per-lane write enables |
| addr | input | AW | External word address |
| oe_n | input | 1 | Asynchronous output enable |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
A write takes effect at the edge that samples it. A read sampled at an edge has its data and `dq_oe` due within the same period, with no extra latency. The bench updates its behavioural model at each rising edge and compares `dq_oe` and `dq_out` at the following falling edge, so every result is checked in the period it is due. The asynchronous enable is checked separately: `oe_n` is toggled in the middle of a period and `dq_oe` is sampled a nanosecond later, with no clock edge in between.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_SLEEP,
    CYC_BEGIN,
    CYC_CONT,
    CYC_SUSP
  } cyc_e;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             sleep,
  input  logic             pstrb_n,
  input  logic             cstrb_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             burst_on,
  output cyc_e             kind,
  output logic             we,
  output logic [LANES-1:0] lane_we
);
  logic sel;
  logic wr_req;

  assign sel    = !ce1_n && ce2 && !ce3_n;
  assign wr_req = !gw_n || (!bwe_n && !(&bw_n));

  always_comb begin
    if (sleep)                      kind = CYC_SLEEP;
    else if (!pstrb_n || !cstrb_n)  kind = sel ? CYC_BEGIN : CYC_DESEL;
    else if (burst_on)              kind = adv_n ? CYC_SUSP : CYC_CONT;
    else                            kind = CYC_IDLE;
  end

  always_comb begin
    unique case (kind)
      CYC_BEGIN:          we = pstrb_n && wr_req;
      CYC_CONT, CYC_SUSP: we = wr_req;
      default:            we = 1'b0;
    endcase
  end

  assign lane_we = !we ? '0 : (!gw_n ? '1 : ~bw_n);
endmodule

// File: rtl/sbc_addr.sv
module sbc_addr
  import sbc_pkg::*;
#(
  parameter int AW = 10,
  parameter int BURST_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_e          kind,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] nxt_addr,
  output logic [AW-1:0] cur_addr
);
  localparam int HI = AW - BURST_BITS;
  logic [BURST_BITS-1:0] low_inc;

  assign low_inc = cur_addr[BURST_BITS-1:0] + BURST_BITS'(1);

  always_comb begin
    unique case (kind)
      CYC_BEGIN: nxt_addr = ext_addr;
      CYC_CONT:  nxt_addr = {cur_addr[AW-1:BURST_BITS], low_inc};
      default:   nxt_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur_addr <= '0;
    else     cur_addr <= nxt_addr;
  end

  p_step_wraps_r8: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_CONT) |=>
      (cur_addr[BURST_BITS-1:0] == $past(cur_addr[BURST_BITS-1:0]) + BURST_BITS'(1)) &&
      (cur_addr[AW-1:BURST_BITS] == $past(cur_addr[AW-1:BURST_BITS])));

  p_hold_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_SUSP) |=> $stable(cur_addr));

  logic [HI-1:0] unused_hi;
  assign unused_hi = cur_addr[AW-1:BURST_BITS];
endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
  parameter int AW = 10,
  parameter int LANES = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int DW = LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_we[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sbc_top.sv
module sbc_top
  import sbc_pkg::*;
#(
  parameter int AW = 10,
  parameter int LANES = 4,
  parameter int LANE_W = 8,
  parameter int BURST_BITS = 2,
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             sleep,
  input  logic             pstrb_n,
  input  logic             cstrb_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             oe_n,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  cyc_e             kind;
  logic             we;
  logic [LANES-1:0] lane_we;
  logic             burst_on;
  logic             rd_q;
  logic [AW-1:0]    nxt_addr;
  logic [AW-1:0]    cur_addr;

  sbc_decode #(.LANES(LANES)) i_decode (
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .sleep(sleep),
    .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .burst_on(burst_on),
    .kind(kind), .we(we), .lane_we(lane_we)
  );

  sbc_addr #(.AW(AW), .BURST_BITS(BURST_BITS)) i_addr (
    .clk(clk), .rst(rst), .kind(kind), .ext_addr(addr),
    .nxt_addr(nxt_addr), .cur_addr(cur_addr)
  );

  sbc_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk(clk), .lane_we(lane_we), .waddr(nxt_addr), .wdata(dq_in),
    .raddr(cur_addr), .rdata(dq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_on <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      unique case (kind)
        CYC_BEGIN, CYC_CONT, CYC_SUSP: begin
          burst_on <= 1'b1;
          rd_q     <= !we;
        end
        default: begin
          burst_on <= 1'b0;
          rd_q     <= 1'b0;
        end
      endcase
    end
  end

  assign dq_oe = rd_q && !oe_n;

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !rd_q);

  p_pstrb_reads_r4: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !pstrb_n && !ce1_n && ce2 && !ce3_n) |=> rd_q);

  p_desel_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!sleep && (!pstrb_n || !cstrb_n) && !(!ce1_n && ce2 && !ce3_n)) |=> (!rd_q && !burst_on));

  p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!rd_q && !burst_on));

  p_write_masks_oe_r11: assert property (@(posedge clk) disable iff (rst)
    (|lane_we) |=> !dq_oe);
endmodule

// File: tb/test_sbc_top.sv
`timescale 1ns/100ps
module test_sbc_top;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0, sleep = 1'b0;
  logic pstrb_n = 1'b1, cstrb_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic oe_n = 1'b0;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic dq_oe;

  int n_run = 0;
  int n_fail = 0;

  logic [31:0] mm [DEPTH];
  logic [AW-1:0] ma = '0;
  bit m_on = 0;
  bit m_rd = 0;

  always #2.5 clk = ~clk;

  sbc_top #(.AW(AW)) i_sbc_top (
    .clk(clk), .rst(rst), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .sleep(sleep),
    .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic model_edge();
    bit sel = !ce1_n && ce2 && !ce3_n;
    bit wr = !gw_n || (!bwe_n && (bw_n != 4'hF));
    bit do_wr = 0;
    if (rst) begin
      m_on = 0; m_rd = 0; ma = '0;
    end else if (sleep) begin
      m_on = 0; m_rd = 0;
    end else if (!pstrb_n || !cstrb_n) begin
      if (!sel) begin
        m_on = 0; m_rd = 0;
      end else begin
        ma = addr; m_on = 1;
        do_wr = pstrb_n && wr;
        m_rd = !do_wr;
      end
    end else if (m_on) begin
      if (!adv_n) ma[1:0] = ma[1:0] + 2'd1;
      do_wr = wr;
      m_rd = !do_wr;
    end else begin
      m_rd = 0;
    end
    if (do_wr) begin
      for (int i = 0; i < 4; i++)
        if (!gw_n || !bw_n[i]) mm[ma][i*8 +: 8] = dq_in[i*8 +: 8];
    end
  endtask

  task automatic compare(string tag);
    bit exp_en = m_rd && !oe_n;
    n_run++;
    if (dq_oe !== exp_en) begin
      n_fail++;
      $display("FAIL %s: dq_oe=%b expected %b", tag, dq_oe, exp_en);
    end else if (exp_en && dq_out !== mm[ma]) begin
      n_fail++;
      $display("FAIL %s: dq_out=%h expected %h (addr %0h)", tag, dq_out, mm[ma], ma);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet_ctl();
    pstrb_n = 1; cstrb_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1;
    cyc("R1"); cyc("R1");
    rst = 0; quiet_ctl();
    cyc("R1"); cyc("R1");

    // R5: controller strobe begins a global write at 0x10
    cstrb_n = 0; addr = 10'h010; gw_n = 0; dq_in = 32'hA0A0_0000;
    cyc("R5");
    // R8: continue writes through 0x11..0x13 using byte enables
    cstrb_n = 1; gw_n = 1; bwe_n = 0; bw_n = 4'h0; adv_n = 0;
    for (int k = 1; k < 4; k++) begin
      dq_in = 32'hA0A0_0000 + k;
      cyc("R8");
    end
    // R3: lanes 0 and 2 only at 0x12
    cstrb_n = 0; addr = 10'h012; bw_n = 4'b1010; dq_in = 32'hFFFF_FFFF; adv_n = 1;
    cyc("R3");
    quiet_ctl();
    cstrb_n = 0; addr = 10'h012;
    cyc("R3");
    // R4: processor strobe with write asserted still reads
    quiet_ctl(); pstrb_n = 0; addr = 10'h012; gw_n = 0; dq_in = 32'h1234_5678;
    cyc("R4");
    // R8/R12: step 0x13, wrap to 0x10
    quiet_ctl(); adv_n = 0;
    cyc("R8"); cyc("R8");
    // R9: suspend holds 0x10
    adv_n = 1;
    cyc("R9"); cyc("R9");
    // R2: byte-write enable without lanes, lanes without enable -> reads
    bwe_n = 0; bw_n = 4'hF; dq_in = 32'hDEAD_BEEF; adv_n = 0;
    cyc("R2");
    bwe_n = 1; bw_n = 4'h0;
    cyc("R2");
    // R10: asynchronous output enable
    oe_n = 1; #1;
    compare("R10");
    oe_n = 0; #1;
    compare("R10");
    // R11: write masks output enable; R2 per-lane write via bwe_n
    bwe_n = 0; bw_n = 4'b1110; dq_in = 32'h0000_00C3;
    cyc("R11");
    quiet_ctl(); adv_n = 1;
    cyc("R2");
    // R6: deselect variants
    cstrb_n = 0; ce2 = 0; addr = 10'h011; gw_n = 0; dq_in = 32'h5555_5555;
    cyc("R6");
    quiet_ctl(); ce2 = 1; adv_n = 0; gw_n = 0;
    cyc("R6");
    quiet_ctl(); pstrb_n = 0; ce1_n = 1;
    cyc("R6");
    quiet_ctl(); ce1_n = 0; cstrb_n = 0; ce3_n = 1; gw_n = 0;
    cyc("R6");
    quiet_ctl(); ce3_n = 0;
    pstrb_n = 0; addr = 10'h011;
    cyc("R6");
    // R7: sleep ignores controls, blocks writes, closes burst
    quiet_ctl(); sleep = 1; cstrb_n = 0; gw_n = 0; addr = 10'h011; dq_in = 32'h7777_7777;
    cyc("R7"); cyc("R7");
    quiet_ctl(); sleep = 0; adv_n = 0;
    cyc("R7");
    pstrb_n = 0; addr = 10'h011;
    cyc("R7");
    // R4/R5: write on the clock after a processor-strobe read
    quiet_ctl(); pstrb_n = 0; addr = 10'h013;
    cyc("R4");
    quiet_ctl(); adv_n = 0; gw_n = 0; dq_in = 32'h0BAD_CAFE;
    cyc("R4");
    quiet_ctl(); cstrb_n = 0; addr = 10'h010;
    cyc("R12");
    quiet_ctl();
    cyc("R12");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule